// File: doc/BRIEF.md
# Two-Level Lookahead Adder, 16 Bits

This block adds two 16-bit operands and a carry input and returns a 16-bit sum, a carry output and a signed overflow flag. It serves both unsigned and two's-complement operands. It is purely combinational, so the outputs follow the inputs within the same cycle and the block holds no state.

Each bit position first decides its carry behaviour. Both bits 0 kills any incoming carry. Both bits 1 generates a carry. Bits that differ pass the incoming carry along. The operand is split into four 4-bit groups. Inside a group, every internal carry is a direct sum-of-products of the bit terms and the group's carry-in, with no bit-to-bit chain. Each group also summarises itself as a group generate term and a group propagate term. A second lookahead stage, built from the same equations, turns those summaries and the adder's carry input into the carry into every group and the final carry out.

The block has no states and no transitions; it is a single combinational datapath.

Top module: `cla_adder16`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, operands taken as unsigned.
- R2: `cout_o` equals bit 16 of the 17-bit result of `a_i + b_i + cin_i`.
- R3: `ovf_o` is 1 exactly when `a_i[15]` equals `b_i[15]` and `sum_o[15]` differs from them. Bit 15 is the sign bit of a two's-complement operand.
- R4: A bit position where both operand bits are 0 stops a carry. For example, 0x0FFF + 0x0000 + 1 gives sum 0x1000 and carry out 0.
- R5: A bit position where both operand bits are 1 produces a carry out of that position whatever arrives from below. For example, 0x8000 + 0x8000 + 0 gives sum 0x0000, carry out 1 and overflow 1.
- R6: A carry input passes through all 16 positions when every bit pair differs. For example, 0xFFFF + 0x0000 + 1 and 0xAAAA + 0x5555 + 1 both give sum 0x0000 and carry out 1.
- R7: The carry into each 4-bit group, taken from the second lookahead stage, matches the arithmetic carry across that group boundary. For example, 0x000F + 0x0001 gives 0x0010, and 0x0FFF + 0x0001 gives 0x1000.
- R8: The outputs settle within the cycle in which the inputs change, with no register in the path. A new operand pair on every cycle gives the matching result in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| ovf_o | output | 1 | Signed overflow: carry into bit 15 XOR carry out of bit 15 |

## Verification
Random operands seldom produce a carry that must pass through every group, because that needs every bit pair to differ at once. Random stimulus therefore almost never tests whether the second stage routes a carry correctly across several group boundaries. The directed vectors cover this. They use complementary operands such as 0xAAAA with 0x5555, and operands of all ones plus a single one. The carry then has to cross one, two, three and then all four group boundaries. Further vectors place a kill or a generate pair right at a boundary, so that a wrongly formed group term would change the sum.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int CLA_DEFAULT_WIDTH   = 16;
    localparam int CLA_DEFAULT_GROUP_W = 4;
endpackage

// File: rtl/cla_pg_bits.sv
module cla_pg_bits #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o
);
    always_comb begin
        gen_o  = a_i & b_i;
        prop_o = a_i ^ b_i;
    end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
    parameter int N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         carry_i,
    output logic [N:0]   carry_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);
    // Carry out of position hi as a flat sum of products:
    // each generate term ANDed with every propagate above it,
    // plus the incoming carry ANDed with all propagates up to hi.
    function automatic logic span_carry(input logic [N-1:0] g,
                                        input logic [N-1:0] p,
                                        input logic         c,
                                        input int           hi);
        logic res;
        logic term;
        res = 1'b0;
        for (int j = 0; j <= hi; j++) begin
            term = g[j];
            for (int k = j + 1; k <= hi; k++) begin
                term = term & p[k];
            end
            res = res | term;
        end
        term = c;
        for (int k = 0; k <= hi; k++) begin
            term = term & p[k];
        end
        return res | term;
    endfunction

    always_comb begin
        carry_o[0] = carry_i;
        for (int i = 0; i < N; i++) begin
            carry_o[i+1] = span_carry(gen_i, prop_i, carry_i, i);
        end
        grp_gen_o  = span_carry(gen_i, prop_i, 1'b0, N - 1);
        grp_prop_o = &prop_i;
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            // R5
            generate_chk: assert (!gen_i[i] || carry_o[i+1])
                else $error("generate at %0d did not carry", i);
            // R4
            kill_chk: assert (gen_i[i] || prop_i[i] || !carry_o[i+1])
                else $error("kill at %0d let a carry through", i);
        end
        // R6
        pass_chk: assert (!grp_prop_o || (carry_o[N] == carry_i))
            else $error("full propagate did not pass carry");
        // R7
        group_gen_chk: assert (!grp_gen_o || carry_o[N])
            else $error("group generate without carry out");
    end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
    parameter int WIDTH   = cla_pkg::CLA_DEFAULT_WIDTH,
    parameter int GROUP_W = cla_pkg::CLA_DEFAULT_GROUP_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int NGRP = WIDTH / GROUP_W;

    logic [WIDTH-1:0] bit_gen;
    logic [WIDTH-1:0] bit_prop;
    logic [WIDTH-1:0] bit_carry;
    logic [NGRP-1:0]  grp_gen;
    logic [NGRP-1:0]  grp_prop;
    logic [NGRP:0]    top_carry;
    logic [GROUP_W:0] grp_carry [NGRP];
    logic             all_gen;
    logic             all_prop;

    cla_pg_bits #(.W(WIDTH)) u_pg (
        .a_i    (a_i),
        .b_i    (b_i),
        .gen_o  (bit_gen),
        .prop_o (bit_prop)
    );

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        cla_lookahead #(.N(GROUP_W)) u_grp (
            .gen_i      (bit_gen[k*GROUP_W +: GROUP_W]),
            .prop_i     (bit_prop[k*GROUP_W +: GROUP_W]),
            .carry_i    (top_carry[k]),
            .carry_o    (grp_carry[k]),
            .grp_gen_o  (grp_gen[k]),
            .grp_prop_o (grp_prop[k])
        );
        for (genvar i = 0; i < GROUP_W; i++) begin : g_bit
            assign bit_carry[k*GROUP_W + i] = grp_carry[k][i];
        end
    end

    cla_lookahead #(.N(NGRP)) u_top (
        .gen_i      (grp_gen),
        .prop_i     (grp_prop),
        .carry_i    (cin_i),
        .carry_o    (top_carry),
        .grp_gen_o  (all_gen),
        .grp_prop_o (all_prop)
    );

    always_comb begin
        sum_o  = bit_prop ^ bit_carry;
        cout_o = top_carry[NGRP];
        ovf_o  = top_carry[NGRP] ^ bit_carry[WIDTH-1];
    end

    always_comb begin
        // R1
        sum_chk: assert ({cout_o, sum_o} ==
                         ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
            else $error("sum mismatch");
        // R3
        ovf_chk: assert (ovf_o == ((a_i[WIDTH-1] == b_i[WIDTH-1]) &&
                                   (sum_o[WIDTH-1] != a_i[WIDTH-1])))
            else $error("overflow flag mismatch");
        // R2
        cout_chk: assert (!(all_gen || (all_prop && cin_i)) || cout_o)
            else $error("carry out missing");
        for (int k = 0; k < NGRP; k++) begin
            // R7
            boundary_chk: assert (grp_carry[k][GROUP_W] == top_carry[k+1])
                else $error("group %0d boundary carry disagrees", k);
        end
    end
endmodule

// File: tb/cla_adder16_bench.sv
module cla_adder16_bench;
    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        logic [15:0] sum;
        logic        cout;
        logic        ovf;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a   = '0;
    logic [15:0] b   = '0;
    logic        cin = 1'b0;
    logic [15:0] sum;
    logic        cout;
    logic        ovf;
    exp_t        sb_q[$];
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cla_adder16 u_cla_adder16 (
        .a_i    (a),
        .b_i    (b),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout),
        .ovf_o  (ovf)
    );

    task automatic drive(input logic [15:0] x, input logic [15:0] y,
                         input logic c, input string tag);
        exp_t e;
        logic [16:0] full;
        @(posedge clk);
        a   = x;
        b   = y;
        cin = c;
        full   = {1'b0, x} + {1'b0, y} + {16'b0, c};
        e.sum  = full[15:0];
        e.cout = full[16];
        e.ovf  = (x[15] == y[15]) && (full[15] != x[15]);
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (sum !== e.sum) begin
                errors++;
                $display("FAIL %s sum: a=%h b=%h cin=%b got %h exp %h",
                         e.tag, a, b, cin, sum, e.sum);
            end
            checks++;
            if (cout !== e.cout) begin
                errors++;
                $display("FAIL %s/R2 cout: a=%h b=%h cin=%b got %b exp %b",
                         e.tag, a, b, cin, cout, e.cout);
            end
            checks++;
            if (ovf !== e.ovf) begin
                errors++;
                $display("FAIL %s/R3 ovf: a=%h b=%h cin=%b got %b exp %b",
                         e.tag, a, b, cin, ovf, e.ovf);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R1 idle operands
        drive(16'h0000, 16'h0000, 1'b0, "R1");
        // R4 kill stops carry at bit 12
        drive(16'h0FFF, 16'h0000, 1'b1, "R4");
        drive(16'h00F0, 16'h0000, 1'b1, "R4");
        // R5 generate pairs
        drive(16'h8000, 16'h8000, 1'b0, "R5");
        drive(16'h0001, 16'h0001, 1'b0, "R5");
        drive(16'h0010, 16'h0010, 1'b1, "R5");
        // R6 full-width propagate
        drive(16'hFFFF, 16'h0000, 1'b1, "R6");
        drive(16'hAAAA, 16'h5555, 1'b1, "R6");
        drive(16'hFFFF, 16'h0001, 1'b0, "R6");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R6");
        // R7 carries across one, two, three group boundaries
        drive(16'h000F, 16'h0001, 1'b0, "R7");
        drive(16'h00FF, 16'h0001, 1'b0, "R7");
        drive(16'h0FFF, 16'h0001, 1'b0, "R7");
        drive(16'h0F0F, 16'h00F1, 1'b0, "R7");
        // R3 signed overflow cases
        drive(16'h7FFF, 16'h0001, 1'b0, "R3");
        drive(16'h8000, 16'hFFFF, 1'b0, "R3");
        drive(16'h7FFF, 16'h8000, 1'b1, "R3");
        drive(16'h7FFF, 16'h7FFF, 1'b1, "R3");
        // R8 a new random pair on every cycle
        for (int n = 0; n < 400; n++) begin
            drive(16'($urandom), 16'($urandom), 1'($urandom), "R8");
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, got hang exp done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule